// File: doc/BRIEF.md
# Descriptor-Driven Peripheral Channel Controller

This block moves data between a byte-wide peripheral channel and a simple memory port, without the processor taking part in each byte. Up to eight devices share the channel, and each has a fixed three-bit address. For each device, software writes two descriptors. The start descriptor sets the transfer mode and the first memory address. The completion descriptor sets the byte count and the program level that the completion interrupt is steered to. After that, each time a device raises its request line, the controller serves it by moving one byte (byte modes) or up to four bytes (word modes). The address advances and the remaining count drops with every byte. When the count reaches zero, the device returns to the inactive mode and the controller raises a completion interrupt.

Every byte on the channel carries odd parity. Parity is checked on bytes from a device and on bytes read from memory, and generated on bytes written to a device or to memory. A parity fault stops the device's transfer, sets a sticky per-device error flag and raises the shared error interrupt. A command path also gives the processor direct access to a device:
- a control byte, with or without leaving the device's transfer mode;
- a read of one byte from the device into a result register;
- a write of one byte from the processor to the device.

Top module: `pio_chan_ctrl`

## Requirements
- R1: A start descriptor write (`cfg_term`=0) takes the mode from `cfg_data[18:16]` and the start address from `cfg_data[15:0]`. A completion descriptor write (`cfg_term`=1) takes the byte count from `cfg_data[15:0]` and the interrupt level from `cfg_data[18:16]`. The mode codes are 0 inactive, 1 alarm, 2 input byte, 3 output byte, 4 input word and 5 output word. Codes 6 and 7 load as inactive.
- R2: A device in a byte mode moves exactly one byte per service. Each byte increments the memory address by one and decrements the count by one. Output modes read memory and then strobe `dev_wr`. Input modes strobe `dev_rd` and then write memory.
- R3: A device in a word mode moves four bytes per service, but stops as soon as its count reaches zero. The total number of bytes moved equals the loaded count.
- R4: When a device's count reaches zero, its mode reads back as inactive (0) and its count reads back as 0. `irq_done` pulses for exactly one cycle, with `irq_dev` set to the device and `irq_lvl` set to its descriptor level.
- R5: Every byte driven on `dev_wdata` (with `dev_wr` or `dev_ctl`) and on `mem_wdata` (with `mem_wr`) has odd parity together with `dev_wpar` or `mem_wpar`.
- R6: A byte from a device, or a byte read from memory, whose parity is even aborts the device's transfer. No further byte of that device is moved. Its mode becomes inactive and `err_status` bit n is set and stays set. `irq_err` is high while any bit of `err_status` is set. `err_clr` bit n clears bit n.
- R7: When several enabled devices request in the same cycle, the device with the lowest address is served first.
- R8: When an alarm-mode device requests, `irq_done` is raised with that device's level. No memory or device data strobe occurs, and the device stays in alarm mode.
- R9: Commands are accepted while `cmd_ready` is high, and `cmd_done` pulses when a command completes. The four command codes on `cmd_op` are:
  - 0: strobe `dev_ctl` with `cmd_data`.
  - 1: strobe `dev_ctl` with `cmd_data` and also set the device's mode to inactive.
  - 2: strobe `dev_rd` and return the byte on `cmd_rdata`.
  - 3: strobe `dev_wr` with `cmd_data`.
- R10: A request from a device that is inactive, or that is in a transfer mode with a count of zero, causes no strobe.
- R11: At most one of `mem_rd`, `mem_wr`, `dev_rd`, `dev_wr` and `dev_ctl` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_term | input | 1 | 0 selects the start descriptor, 1 selects the completion descriptor |
| cfg_dev | input | 3 | Device whose descriptor is written |
| cfg_data | input | 32 | Descriptor contents |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code |
| cmd_dev | input | 3 | Command target device |
| cmd_data | input | 8 | Command byte |
| cmd_ready | output | 1 | Controller idle and accepting a command |
| cmd_done | output | 1 | Command complete pulse |
| cmd_rdata | output | 8 | Byte returned by a read command |
| dev_req | input | 8 | Per-device service request |
| dev_sel | output | 3 | Device addressed on the channel |
| dev_wr | output | 1 | Data byte to device strobe |
| dev_rd | output | 1 | Data byte from device strobe |
| dev_ctl | output | 1 | Control byte to device strobe |
| dev_wdata | output | 8 | Byte to device |
| dev_wpar | output | 1 | Parity bit to device |
| dev_rdata | input | 8 | Byte from device, valid while dev_rd is high |
| dev_rpar | input | 1 | Parity bit from device |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read, data returned one cycle later |
| mem_wr | output | 1 | Memory write |
| mem_wdata | output | 8 | Memory write byte |
| mem_wpar | output | 1 | Memory write parity |
| mem_rdata | input | 8 | Memory read byte |
| mem_rpar | input | 1 | Memory read parity |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_dev | output | 3 | Device that completed |
| irq_lvl | output | 3 | Program level of the completion interrupt |
| irq_err | output | 1 | Shared error interrupt |
| err_status | output | 8 | Sticky per-device parity error flags |
| err_clr | input | 8 | Per-device error flag clear |
| stat_dev | input | 3 | Device selected for status readback |
| stat_mode | output | 3 | Current mode of the selected device |
| stat_cnt | output | 16 | Remaining count of the selected device |

## Verification
The hardest situation to reach is a parity fault in the middle of a multi-byte transfer. The bench must show that the abort lands on the right device, that no later byte of that device moves, and that the memory word beyond the faulty byte is untouched. The device model gives each device its own bad-parity flag, which can corrupt the returned parity. The memory model stores a parity bit beside each byte, so a location can be preloaded with even parity. This lets the bench trigger either fault on a chosen byte and then count strobes and memory writes through the ports. The same-cycle priority case is reached by raising two request lines at the same clock edge.

// File: rtl/chan_pkg.sv
package chan_pkg;

   typedef enum logic [2:0] {
      MD_IDLE     = 3'd0,
      MD_ALARM    = 3'd1,
      MD_IN_BYTE  = 3'd2,
      MD_OUT_BYTE = 3'd3,
      MD_IN_WORD  = 3'd4,
      MD_OUT_WORD = 3'd5
   } xfer_mode_e;

   typedef enum logic [1:0] {
      OP_CTL      = 2'd0,
      OP_CTL_EXIT = 2'd1,
      OP_READ     = 2'd2,
      OP_WRITE    = 2'd3
   } dev_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_MEM_RD,
      ST_MEM_CHK,
      ST_DEV_WR,
      ST_DEV_RD,
      ST_MEM_WR,
      ST_NEXT,
      ST_DONE,
      ST_CMD,
      ST_CMD_END
   } eng_state_e;

   // parity bit that makes the nine-bit group odd
   function automatic logic odd_bit(input logic [7:0] d);
      return ~^d;
   endfunction

   function automatic logic par_good(input logic [7:0] d, input logic p);
      return ^{d, p};
   endfunction

   function automatic logic is_input(input xfer_mode_e m);
      return (m == MD_IN_BYTE) || (m == MD_IN_WORD);
   endfunction

   function automatic logic is_word(input xfer_mode_e m);
      return (m == MD_IN_WORD) || (m == MD_OUT_WORD);
   endfunction

   function automatic logic is_xfer(input xfer_mode_e m);
      return (m == MD_IN_BYTE) || (m == MD_OUT_BYTE) ||
             (m == MD_IN_WORD) || (m == MD_OUT_WORD);
   endfunction

endpackage

// File: rtl/chan_arbiter.sv
module chan_arbiter #(
   parameter int N     = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic             gnt_vld,
   output logic [IDX_W-1:0] gnt_idx
);

   if (N < 2) begin : g_bad_n
      $error("chan_arbiter: N must be at least 2");
   end

   // scan from the top so the lowest requesting index is left standing
   always_comb begin
      gnt_vld = 1'b0;
      gnt_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt_vld = 1'b1;
            gnt_idx = IDX_W'(i);
         end
      end
   end

   logic [N-1:0] below_mask;
   assign below_mask = (N'(1) << gnt_idx) - N'(1);

   AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |-> (req[gnt_idx] && ((req & below_mask) == '0))); // R7

endmodule

// File: rtl/chan_desc_file.sv
module chan_desc_file
   import chan_pkg::*;
#(
   parameter int NDEV   = 8,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int LVL_W  = 3,
   localparam int DEV_W = $clog2(NDEV)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_term,
   input  logic [DEV_W-1:0]  cfg_dev,
   input  logic [31:0]       cfg_data,
   input  logic              upd_we,
   input  logic [DEV_W-1:0]  upd_dev,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [CNT_W-1:0]  upd_cnt,
   input  logic              stop_we,
   input  logic [DEV_W-1:0]  stop_dev,
   input  logic              err_we,
   input  logic [DEV_W-1:0]  err_dev,
   input  logic [NDEV-1:0]   err_clr,
   input  logic [DEV_W-1:0]  rd_dev,
   output xfer_mode_e        rd_mode,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_cnt,
   output logic [LVL_W-1:0]  rd_lvl,
   input  logic [DEV_W-1:0]  st_dev,
   output xfer_mode_e        st_mode,
   output logic [CNT_W-1:0]  st_cnt,
   output logic [NDEV-1:0]   live,
   output logic [NDEV-1:0]   err_bits
);

   localparam int MODE_LSB = 16;

   if (ADDR_W > 16 || CNT_W > 16) begin : g_bad_width
      $error("chan_desc_file: address and count fields hold at most 16 bits");
   end
   if (LVL_W < 1 || LVL_W > 13) begin : g_bad_lvl
      $error("chan_desc_file: LVL_W out of range");
   end
   if (NDEV != (1 << DEV_W)) begin : g_bad_ndev
      $error("chan_desc_file: NDEV must be a power of two");
   end

   xfer_mode_e        mode_q [NDEV];
   logic [ADDR_W-1:0] addr_q [NDEV];
   logic [CNT_W-1:0]  cnt_q  [NDEV];
   logic [LVL_W-1:0]  lvl_q  [NDEV];

   logic       unused_cfg;
   xfer_mode_e cfg_mode;
   assign unused_cfg = ^cfg_data;
   assign cfg_mode   = (cfg_data[MODE_LSB+2:MODE_LSB] > 3'd5) ? MD_IDLE
                       : xfer_mode_e'(cfg_data[MODE_LSB+2:MODE_LSB]);

   for (genvar i = 0; i < NDEV; i++) begin : g_dev
      logic cfg_hit, upd_hit, stop_hit, err_hit;
      assign cfg_hit  = cfg_we  && (cfg_dev  == DEV_W'(i));
      assign upd_hit  = upd_we  && (upd_dev  == DEV_W'(i));
      assign stop_hit = stop_we && (stop_dev == DEV_W'(i));
      assign err_hit  = err_we  && (err_dev  == DEV_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q[i] <= MD_IDLE;
            addr_q[i] <= '0;
            cnt_q[i]  <= '0;
            lvl_q[i]  <= '0;
         end else if (cfg_hit) begin
            if (!cfg_term) begin
               mode_q[i] <= cfg_mode;
               addr_q[i] <= cfg_data[ADDR_W-1:0];
            end else begin
               cnt_q[i] <= cfg_data[CNT_W-1:0];
               lvl_q[i] <= cfg_data[MODE_LSB +: LVL_W];
            end
         end else begin
            if (upd_hit) begin
               addr_q[i] <= upd_addr;
               cnt_q[i]  <= upd_cnt;
            end
            if (stop_hit) begin
               mode_q[i] <= MD_IDLE;
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            err_bits[i] <= 1'b0;
         end else if (err_hit) begin
            err_bits[i] <= 1'b1;
         end else if (err_clr[i]) begin
            err_bits[i] <= 1'b0;
         end
      end

      assign live[i] = (mode_q[i] == MD_ALARM) ||
                       (is_xfer(mode_q[i]) && (cnt_q[i] != '0));

      AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (err_hit && stop_hit && !cfg_hit) |=> (mode_q[i] == MD_IDLE && err_bits[i])); // R6
   end

   assign rd_mode = mode_q[rd_dev];
   assign rd_addr = addr_q[rd_dev];
   assign rd_cnt  = cnt_q[rd_dev];
   assign rd_lvl  = lvl_q[rd_dev];
   assign st_mode = mode_q[st_dev];
   assign st_cnt  = cnt_q[st_dev];

endmodule

// File: rtl/chan_engine.sv
module chan_engine
   import chan_pkg::*;
#(
   parameter int NDEV       = 8,
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 16,
   parameter int LVL_W      = 3,
   parameter int WORD_BYTES = 4,
   localparam int DEV_W     = $clog2(NDEV),
   localparam int BEAT_W    = $clog2(WORD_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gnt_vld,
   input  logic [DEV_W-1:0]  gnt_idx,
   input  xfer_mode_e        rd_mode,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [CNT_W-1:0]  rd_cnt,
   input  logic [LVL_W-1:0]  rd_lvl,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [DEV_W-1:0]  cmd_dev,
   input  logic [7:0]        cmd_data,
   output logic              cmd_ready,
   output logic              cmd_done,
   output logic [7:0]        cmd_rdata,
   output logic [DEV_W-1:0]  dev_sel,
   output logic              dev_wr,
   output logic              dev_rd,
   output logic              dev_ctl,
   output logic [7:0]        dev_wdata,
   output logic              dev_wpar,
   input  logic [7:0]        dev_rdata,
   input  logic              dev_rpar,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   output logic              mem_wpar,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_rpar,
   output logic              upd_we,
   output logic [ADDR_W-1:0] upd_addr,
   output logic [CNT_W-1:0]  upd_cnt,
   output logic              stop_we,
   output logic              err_we,
   output logic              irq_done,
   output logic [DEV_W-1:0]  irq_dev,
   output logic [LVL_W-1:0]  irq_lvl
);

   if (WORD_BYTES < 2) begin : g_bad_word
      $error("chan_engine: WORD_BYTES must be at least 2");
   end

   eng_state_e        state;
   logic [DEV_W-1:0]  cur_dev;
   xfer_mode_e        cur_mode;
   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  cur_cnt;
   logic [LVL_W-1:0]  cur_lvl;
   logic [BEAT_W-1:0] beats;
   logic [7:0]        data_q;
   logic [7:0]        rdata_q;
   dev_op_e           op_q;

   logic mem_bad, dev_bad, abort, last_byte, svc_end;
   assign mem_bad   = !par_good(mem_rdata, mem_rpar);
   assign dev_bad   = !par_good(dev_rdata, dev_rpar);
   assign abort     = ((state == ST_MEM_CHK) && mem_bad) ||
                      ((state == ST_DEV_RD) && dev_bad);
   assign last_byte = (cur_cnt == CNT_W'(1));
   assign svc_end   = (beats == BEAT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_dev  <= '0;
         cur_mode <= MD_IDLE;
         cur_addr <= '0;
         cur_cnt  <= '0;
         cur_lvl  <= '0;
         beats    <= '0;
         data_q   <= '0;
         rdata_q  <= '0;
         op_q     <= OP_CTL;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (cmd_valid) begin
                  cur_dev <= cmd_dev;
                  op_q    <= dev_op_e'(cmd_op);
                  data_q  <= cmd_data;
                  state   <= ST_CMD;
               end else if (gnt_vld) begin
                  cur_dev  <= gnt_idx;
                  cur_mode <= rd_mode;
                  cur_addr <= rd_addr;
                  cur_cnt  <= rd_cnt;
                  cur_lvl  <= rd_lvl;
                  beats    <= is_word(rd_mode) ? BEAT_W'(WORD_BYTES) : BEAT_W'(1);
                  if (rd_mode == MD_ALARM) begin
                     state <= ST_DONE;
                  end else if (is_input(rd_mode)) begin
                     state <= ST_DEV_RD;
                  end else begin
                     state <= ST_MEM_RD;
                  end
               end
            end
            ST_MEM_RD: state <= ST_MEM_CHK;
            ST_MEM_CHK: begin
               if (mem_bad) begin
                  state <= ST_IDLE;
               end else begin
                  data_q <= mem_rdata;
                  state  <= ST_DEV_WR;
               end
            end
            ST_DEV_WR: state <= ST_NEXT;
            ST_DEV_RD: begin
               if (dev_bad) begin
                  state <= ST_IDLE;
               end else begin
                  data_q <= dev_rdata;
                  state  <= ST_MEM_WR;
               end
            end
            ST_MEM_WR: state <= ST_NEXT;
            ST_NEXT: begin
               cur_addr <= upd_addr;
               cur_cnt  <= upd_cnt;
               beats    <= beats - BEAT_W'(1);
               if (last_byte) begin
                  state <= ST_DONE;
               end else if (svc_end) begin
                  state <= ST_IDLE;
               end else if (is_input(cur_mode)) begin
                  state <= ST_DEV_RD;
               end else begin
                  state <= ST_MEM_RD;
               end
            end
            ST_DONE: state <= ST_IDLE;
            ST_CMD: begin
               if (op_q == OP_READ) begin
                  rdata_q <= dev_rdata;
               end
               state <= ST_CMD_END;
            end
            ST_CMD_END: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic in_cmd;
   assign in_cmd = (state == ST_CMD);

   assign cmd_ready = (state == ST_IDLE);
   assign cmd_done  = (state == ST_CMD_END);
   assign cmd_rdata = rdata_q;

   assign dev_sel   = cur_dev;
   assign dev_wr    = (state == ST_DEV_WR) || (in_cmd && op_q == OP_WRITE);
   assign dev_rd    = (state == ST_DEV_RD) || (in_cmd && op_q == OP_READ);
   assign dev_ctl   = in_cmd && (op_q == OP_CTL || op_q == OP_CTL_EXIT);
   assign dev_wdata = data_q;
   assign dev_wpar  = odd_bit(data_q);

   assign mem_addr  = cur_addr;
   assign mem_rd    = (state == ST_MEM_RD);
   assign mem_wr    = (state == ST_MEM_WR);
   assign mem_wdata = data_q;
   assign mem_wpar  = odd_bit(data_q);

   assign upd_we    = (state == ST_NEXT);
   assign upd_addr  = cur_addr + ADDR_W'(1);
   assign upd_cnt   = cur_cnt - CNT_W'(1);
   assign stop_we   = abort || ((state == ST_NEXT) && last_byte) ||
                      (in_cmd && op_q == OP_CTL_EXIT);
   assign err_we    = abort || (in_cmd && op_q == OP_READ && dev_bad);

   assign irq_done  = (state == ST_DONE);
   assign irq_dev   = cur_dev;
   assign irq_lvl   = cur_lvl;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr, dev_rd, dev_wr, dev_ctl})); // R11

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_NEXT) |-> (cur_cnt != '0)); // R3

   AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_done && cur_mode != MD_ALARM) |-> (cur_cnt == '0)); // R4

   AST_QUIET_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !(mem_rd || mem_wr || dev_rd || dev_wr)); // R6

endmodule

// File: rtl/pio_chan_ctrl.sv
module pio_chan_ctrl
   import chan_pkg::*;
#(
   parameter int NDEV       = 8,
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 16,
   parameter int LVL_W      = 3,
   parameter int WORD_BYTES = 4,
   localparam int DEV_W     = $clog2(NDEV)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_term,
   input  logic [DEV_W-1:0]  cfg_dev,
   input  logic [31:0]       cfg_data,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [DEV_W-1:0]  cmd_dev,
   input  logic [7:0]        cmd_data,
   output logic              cmd_ready,
   output logic              cmd_done,
   output logic [7:0]        cmd_rdata,
   input  logic [NDEV-1:0]   dev_req,
   output logic [DEV_W-1:0]  dev_sel,
   output logic              dev_wr,
   output logic              dev_rd,
   output logic              dev_ctl,
   output logic [7:0]        dev_wdata,
   output logic              dev_wpar,
   input  logic [7:0]        dev_rdata,
   input  logic              dev_rpar,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   output logic              mem_wpar,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_rpar,
   output logic              irq_done,
   output logic [DEV_W-1:0]  irq_dev,
   output logic [LVL_W-1:0]  irq_lvl,
   output logic              irq_err,
   output logic [NDEV-1:0]   err_status,
   input  logic [NDEV-1:0]   err_clr,
   input  logic [DEV_W-1:0]  stat_dev,
   output logic [2:0]        stat_mode,
   output logic [CNT_W-1:0]  stat_cnt
);

   logic              gnt_vld;
   logic [DEV_W-1:0]  gnt_idx;
   xfer_mode_e        rd_mode, st_mode;
   logic [ADDR_W-1:0] rd_addr, upd_addr;
   logic [CNT_W-1:0]  rd_cnt, upd_cnt;
   logic [LVL_W-1:0]  rd_lvl;
   logic              upd_we, stop_we, err_we;
   logic [NDEV-1:0]   live;

   chan_desc_file #(
      .NDEV(NDEV), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LVL_W(LVL_W)
   ) u_desc (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_term(cfg_term), .cfg_dev(cfg_dev), .cfg_data(cfg_data),
      .upd_we(upd_we), .upd_dev(dev_sel), .upd_addr(upd_addr), .upd_cnt(upd_cnt),
      .stop_we(stop_we), .stop_dev(dev_sel),
      .err_we(err_we), .err_dev(dev_sel), .err_clr(err_clr),
      .rd_dev(gnt_idx), .rd_mode(rd_mode), .rd_addr(rd_addr), .rd_cnt(rd_cnt),
      .rd_lvl(rd_lvl),
      .st_dev(stat_dev), .st_mode(st_mode), .st_cnt(stat_cnt),
      .live(live), .err_bits(err_status)
   );

   chan_arbiter #(.N(NDEV)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .req(dev_req & live),
      .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
   );

   chan_engine #(
      .NDEV(NDEV), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LVL_W(LVL_W),
      .WORD_BYTES(WORD_BYTES)
   ) u_eng (
      .clk(clk), .rst_n(rst_n),
      .gnt_vld(gnt_vld), .gnt_idx(gnt_idx),
      .rd_mode(rd_mode), .rd_addr(rd_addr), .rd_cnt(rd_cnt), .rd_lvl(rd_lvl),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_data(cmd_data),
      .cmd_ready(cmd_ready), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
      .dev_sel(dev_sel), .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_ctl(dev_ctl),
      .dev_wdata(dev_wdata), .dev_wpar(dev_wpar),
      .dev_rdata(dev_rdata), .dev_rpar(dev_rpar),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_wpar(mem_wpar),
      .mem_rdata(mem_rdata), .mem_rpar(mem_rpar),
      .upd_we(upd_we), .upd_addr(upd_addr), .upd_cnt(upd_cnt),
      .stop_we(stop_we), .err_we(err_we),
      .irq_done(irq_done), .irq_dev(irq_dev), .irq_lvl(irq_lvl)
   );

   assign irq_err   = |err_status;
   assign stat_mode = st_mode;

   AST_DEV_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_wr || dev_ctl) |-> ^{dev_wdata, dev_wpar}); // R5

   AST_MEM_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ^{mem_wdata, mem_wpar}); // R5

endmodule

// File: tb/pio_chan_ctrl_tb.sv
module pio_chan_ctrl_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_term = 1'b0;
   logic [2:0]  cfg_dev = '0;
   logic [31:0] cfg_data = '0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [2:0]  cmd_dev = '0;
   logic [7:0]  cmd_data = '0;
   logic        cmd_ready, cmd_done;
   logic [7:0]  cmd_rdata;
   logic [7:0]  dev_req = '0;
   logic [2:0]  dev_sel;
   logic        dev_wr, dev_rd, dev_ctl, dev_wpar, dev_rpar;
   logic [7:0]  dev_wdata, dev_rdata;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr, mem_wpar;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        mem_rpar = 1'b0;
   logic        irq_done, irq_err;
   logic [2:0]  irq_dev, irq_lvl;
   logic [7:0]  err_status;
   logic [7:0]  err_clr = '0;
   logic [2:0]  stat_dev = '0;
   logic [2:0]  stat_mode;
   logic [15:0] stat_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   pio_chan_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_term(cfg_term), .cfg_dev(cfg_dev), .cfg_data(cfg_data),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_data(cmd_data),
      .cmd_ready(cmd_ready), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
      .dev_req(dev_req), .dev_sel(dev_sel), .dev_wr(dev_wr), .dev_rd(dev_rd),
      .dev_ctl(dev_ctl), .dev_wdata(dev_wdata), .dev_wpar(dev_wpar),
      .dev_rdata(dev_rdata), .dev_rpar(dev_rpar),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_wpar(mem_wpar),
      .mem_rdata(mem_rdata), .mem_rpar(mem_rpar),
      .irq_done(irq_done), .irq_dev(irq_dev), .irq_lvl(irq_lvl), .irq_err(irq_err),
      .err_status(err_status), .err_clr(err_clr),
      .stat_dev(stat_dev), .stat_mode(stat_mode), .stat_cnt(stat_cnt)
   );

   // ---------------- behavioural memory and devices ----------------
   logic [8:0] mem [0:1023];          // {parity, data}
   logic [7:0] in_val [0:7];
   logic [7:0] bad_par = '0;

   assign dev_rdata = in_val[dev_sel];
   assign dev_rpar  = (~^in_val[dev_sel]) ^ bad_par[dev_sel];

   int total = 0, bad = 0;
   bit finished = 0;
   int wr_n, rd_n, ctl_n, memwr_n, irq_n, multi_n;
   logic [7:0] wr_data [0:15];
   logic [2:0] wr_sel  [0:15];
   logic       wr_par  [0:15];
   logic [7:0] ctl_data;
   logic       ctl_par;
   logic [2:0] last_irq_dev, last_irq_lvl;

   always @(posedge clk) begin
      if (mem_rd) begin
         mem_rdata <= mem[mem_addr[9:0]][7:0];
         mem_rpar  <= mem[mem_addr[9:0]][8];
      end
      if (mem_wr) begin
         mem[mem_addr[9:0]] <= {mem_wpar, mem_wdata};
         memwr_n <= memwr_n + 1;
      end
      if (dev_wr) begin
         wr_data[wr_n[3:0]] <= dev_wdata;
         wr_sel[wr_n[3:0]]  <= dev_sel;
         wr_par[wr_n[3:0]]  <= dev_wpar;
         wr_n <= wr_n + 1;
      end
      if (dev_rd) begin
         in_val[dev_sel] <= in_val[dev_sel] + 8'd1;
         rd_n <= rd_n + 1;
      end
      if (dev_ctl) begin
         ctl_data <= dev_wdata;
         ctl_par  <= dev_wpar;
         ctl_n <= ctl_n + 1;
      end
      if (irq_done) begin
         last_irq_dev <= irq_dev;
         last_irq_lvl <= irq_lvl;
         irq_n <= irq_n + 1;
      end
      if ((32'(mem_rd) + 32'(mem_wr) + 32'(dev_rd) + 32'(dev_wr) + 32'(dev_ctl)) > 1)
         multi_n <= multi_n + 1;
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clr_logs();
      @(negedge clk);
      wr_n = 0; rd_n = 0; ctl_n = 0; memwr_n = 0; irq_n = 0;
   endtask

   task automatic put_mem(input int a, input logic [7:0] d, input bit good);
      mem[a] = {good ? ~^d : ^d, d};
   endtask

   // start descriptor: mode in [18:16], address in [15:0]
   // completion descriptor: level in [18:16], count in [15:0]
   task automatic load_dev(input int dev, input int mode, input int addr,
                           input int cnt, input int lvl);
      @(negedge clk);
      cfg_we = 1; cfg_dev = 3'(dev); cfg_term = 1;
      cfg_data = {13'd0, 3'(lvl), 16'(cnt)};
      @(negedge clk);
      cfg_term = 0; cfg_data = {13'd0, 3'(mode), 16'(addr)};
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic wait_irqs(input int n);
      for (int i = 0; i < 400 && irq_n < n; i++) @(negedge clk);
   endtask

   task automatic read_stat(input int dev);
      @(negedge clk);
      stat_dev = 3'(dev);
      #1;
   endtask

   task automatic do_cmd(input int op, input int dev, input logic [7:0] d);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1; cmd_op = 2'(op); cmd_dev = 3'(dev); cmd_data = d;
      @(negedge clk);
      cmd_valid = 0;
      for (int i = 0; i < 20 && !cmd_done; i++) @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      read_stat(0);
      check(stat_mode == 3'd0, "R1 reset mode", stat_mode, 0);
      check(err_status == 8'd0 && !irq_err, "R6 reset err", err_status, 0);
      check(cmd_ready && !dev_wr && !dev_rd && !mem_rd && !mem_wr, "R11 reset idle",
            cmd_ready, 1);
   endtask

   task automatic t_out_byte();
      logic [7:0] exp [3] = '{8'hA1, 8'hB2, 8'hC3};
      for (int i = 0; i < 3; i++) put_mem(16'h100 + i, exp[i], 1);
      load_dev(3, 3, 16'h100, 3, 5);
      clr_logs();
      dev_req[3] = 1;
      wait_irqs(1);
      dev_req[3] = 0;
      repeat (4) @(negedge clk);
      check(wr_n == 3, "R2 out byte count", wr_n, 3);
      for (int i = 0; i < 3; i++) begin
         check(wr_data[i] == exp[i] && wr_sel[i] == 3'd3, "R2 out byte data",
               wr_data[i], exp[i]);
         check(^{wr_data[i], wr_par[i]}, "R5 out parity odd", wr_par[i], ~^exp[i]);
      end
      check(irq_n == 1 && last_irq_dev == 3 && last_irq_lvl == 5, "R4 irq dev/level",
            {last_irq_dev, last_irq_lvl}, {3'd3, 3'd5});
      read_stat(3);
      check(stat_mode == 3'd0 && stat_cnt == 16'd0, "R4 done state", stat_mode, 0);
   endtask

   task automatic t_in_word();
      in_val[5] = 8'h10;
      load_dev(5, 4, 16'h200, 6, 1);
      clr_logs();
      dev_req[5] = 1;
      wait_irqs(1);
      dev_req[5] = 0;
      repeat (4) @(negedge clk);
      check(rd_n == 6 && memwr_n == 6, "R3 word stops at count", rd_n, 6);
      for (int i = 0; i < 6; i++) begin
         check(mem[16'h200 + i][7:0] == 8'(8'h10 + i), "R3 in word data",
               mem[16'h200 + i][7:0], 8'h10 + i);
         check(^mem[16'h200 + i], "R5 mem parity odd", mem[16'h200 + i], 1);
      end
      read_stat(5);
      check(stat_mode == 3'd0, "R4 in word done", stat_mode, 0);
   endtask

   task automatic t_out_word();
      for (int i = 0; i < 4; i++) put_mem(16'h140 + i, 8'(8'h50 + i), 1);
      load_dev(0, 5, 16'h140, 4, 6);
      clr_logs();
      dev_req[0] = 1;
      wait_irqs(1);
      dev_req[0] = 0;
      repeat (4) @(negedge clk);
      check(wr_n == 4 && wr_data[3] == 8'h53, "R3 out word", wr_n, 4);
      check(last_irq_lvl == 6, "R4 out word level", last_irq_lvl, 6);
   endtask

   task automatic t_priority();
      put_mem(16'h300, 8'h22, 1);
      put_mem(16'h310, 8'h66, 1);
      load_dev(2, 3, 16'h300, 1, 0);
      load_dev(6, 3, 16'h310, 1, 0);
      clr_logs();
      dev_req[2] = 1; dev_req[6] = 1;
      wait_irqs(2);
      dev_req = '0;
      repeat (4) @(negedge clk);
      check(wr_n == 2 && wr_sel[0] == 3'd2 && wr_sel[1] == 3'd6, "R7 lowest first",
            wr_sel[0], 2);
   endtask

   task automatic t_in_parity();
      in_val[4] = 8'h31;
      bad_par[4] = 1;
      load_dev(4, 2, 16'h380, 2, 0);
      mem[16'h380] = 9'h000;
      clr_logs();
      dev_req[4] = 1;
      repeat (20) @(negedge clk);
      dev_req[4] = 0;
      bad_par[4] = 0;
      check(rd_n == 1 && memwr_n == 0 && mem[16'h380] == 9'h000, "R6 in abort",
            memwr_n, 0);
      check(err_status[4] && irq_err && irq_n == 0, "R6 err flag", err_status, 8'h10);
      read_stat(4);
      check(stat_mode == 3'd0, "R6 mode inactive", stat_mode, 0);
      repeat (3) @(negedge clk);
      check(err_status[4], "R6 sticky", err_status, 8'h10);
      err_clr[4] = 1;
      @(negedge clk);
      err_clr[4] = 0;
      check(err_status == 8'd0 && !irq_err, "R6 clear", err_status, 0);
   endtask

   task automatic t_mem_parity();
      put_mem(16'h3A0, 8'h5C, 0);
      put_mem(16'h3A1, 8'h5D, 1);
      load_dev(1, 3, 16'h3A0, 2, 0);
      clr_logs();
      dev_req[1] = 1;
      repeat (20) @(negedge clk);
      dev_req[1] = 0;
      check(wr_n == 0 && err_status == 8'h02 && irq_err, "R6 mem abort",
            {wr_n[7:0], err_status}, 16'h0002);
      err_clr = 8'hFF;
      @(negedge clk);
      err_clr = 0;
   endtask

   task automatic t_alarm();
      load_dev(7, 1, 0, 0, 2);
      clr_logs();
      dev_req[7] = 1;
      @(negedge clk);
      dev_req[7] = 0;
      wait_irqs(1);
      repeat (3) @(negedge clk);
      check(irq_n == 1 && last_irq_dev == 7 && last_irq_lvl == 2, "R8 alarm irq",
            {last_irq_dev, last_irq_lvl}, {3'd7, 3'd2});
      check(wr_n == 0 && rd_n == 0 && memwr_n == 0, "R8 alarm quiet", wr_n + rd_n, 0);
      read_stat(7);
      check(stat_mode == 3'd1, "R8 stays alarm", stat_mode, 1);
   endtask

   task automatic t_commands();
      clr_logs();
      do_cmd(0, 0, 8'h5A);
      @(negedge clk);
      check(ctl_n == 1 && ctl_data == 8'h5A && ^{ctl_data, ctl_par}, "R9 control",
            ctl_data, 8'h5A);
      load_dev(5, 2, 16'h3C0, 9, 0);
      do_cmd(1, 5, 8'h11);
      read_stat(5);
      check(stat_mode == 3'd0 && ctl_n == 2, "R9 control exit", stat_mode, 0);
      in_val[2] = 8'h77;
      do_cmd(2, 2, 8'h00);
      check(cmd_rdata == 8'h77, "R9 read to register", cmd_rdata, 8'h77);
      do_cmd(3, 6, 8'h3C);
      @(negedge clk);
      check(wr_n == 1 && wr_data[0] == 8'h3C && wr_sel[0] == 3'd6, "R9 write",
            wr_data[0], 8'h3C);
   endtask

   task automatic t_ignored();
      load_dev(0, 0, 16'h100, 4, 0);
      load_dev(1, 3, 16'h100, 0, 0);
      load_dev(2, 7, 16'h100, 4, 0);
      clr_logs();
      dev_req[2:0] = 3'b111;
      repeat (20) @(negedge clk);
      dev_req = '0;
      check(wr_n == 0 && rd_n == 0 && irq_n == 0, "R10 ignored requests", wr_n, 0);
      read_stat(2);
      check(stat_mode == 3'd0, "R1 invalid code inactive", stat_mode, 0);
      check(multi_n == 0, "R11 single strobe", multi_n, 0);
   endtask

   initial begin
      multi_n = 0;
      for (int i = 0; i < 1024; i++) mem[i] = 9'h100;
      for (int i = 0; i < 8; i++) in_val[i] = 8'h00;
      wr_n = 0; rd_n = 0; ctl_n = 0; memwr_n = 0; irq_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_out_byte();
      t_in_word();
      t_out_word();
      t_priority();
      t_in_parity();
      t_mem_parity();
      t_alarm();
      t_commands();
      t_ignored();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule